// File: doc/BRIEF.md
# Multiply-Add and Shifted-Immediate Execute Unit

This unit sits in the execute stage of a 24-bit processor pipeline. It performs four operations: a plain add of two register operands, a plain multiply, a three-source multiply-add (first operand times second, plus third), and a load of an immediate shifted left by a 5-bit amount. Add and shifted-immediate results appear combinationally in the cycle the operation is presented. Multiply-type operations use a two-stage pipelined multiplier whose final step reuses the same adder as the plain add.

Multiply latency is exposed to the surrounding pipeline as a stall. The stall covers the accepting cycle and the cycle after it. It drops in the cycle the result becomes valid, two cycles after acceptance. While a multiply is in flight the unit ignores its inputs, so the surrounding pipeline can keep the multiply instruction on the inputs until it retires. All arithmetic is truncated to the datapath width.

Top module: `mac_shift_exu`

## Requirements
- R1: With op code 2'b00 and `in_valid` high on an idle unit, `result` equals (`src_a` + `src_b`) mod 2^24, with `res_valid` high and `stall` low in that same cycle.
- R2: With op code 2'b01 accepted on an idle unit, `result` equals the low 24 bits of `src_a` * `src_b`, with `res_valid` high exactly two cycles after acceptance.
- R3: With op code 2'b10 accepted on an idle unit, `result` equals the low 24 bits of `src_a` * `src_b` + `src_c`, with `res_valid` high exactly two cycles after acceptance.
- R4: With op code 2'b11 and `in_valid` high on an idle unit, `result` equals (`imm` << `shamt`) mod 2^24 in that same cycle, with `res_valid` high and `stall` low.
- R5: For op code 2'b11, a `shamt` value of 24 or more yields a zero result.
- R6: For op codes 2'b01 and 2'b10, `stall` is high in the accepting cycle and in the next cycle, and it is low in the cycle the result is valid.
- R7: In the two cycles after a multiply-type operation is accepted, `in_valid` and all operand inputs are ignored. No extra result is produced, the pending result is unchanged, and `res_valid` is low in the cycle after the result cycle unless a new operation is presented.
- R8: During and after reset, with `in_valid` low and nothing in flight, `res_valid` and `stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the inputs |
| op | input | 2 | Operation code: 00 add, 01 multiply, 10 multiply-add, 11 shifted immediate |
| src_a | input | 24 | First register operand |
| src_b | input | 24 | Second register operand |
| src_c | input | 24 | Third register operand (addend of multiply-add) |
| imm | input | 24 | Immediate for the shift operation |
| shamt | input | 5 | Left shift amount for the shift operation |
| res_valid | output | 1 | `result` carries a finished operation |
| result | output | 24 | Operation result |
| stall | output | 1 | Hold the pipeline; a multiply is in flight |

## Verification
The main risk is a wrong in-flight state in the two multiplier stage flags. A flag that is cleared too early shows within one cycle: `stall` drops while no result is ready, or `res_valid` rises a cycle early with a partial product. A flag that lingers shows two cycles after acceptance: `stall` stays high in the result cycle, or a held input is wrongly accepted and a second result appears. A wrong split of the multiplier halves, or a lost addend in the stage registers, corrupts only the value in the result cycle. The multiply checks therefore use operands with bits set in both halves of the second operand and a non-zero addend.

// File: rtl/mac_shift_exu_pkg.sv
package mac_shift_exu_pkg;
   typedef enum logic [1:0] {
      OP_ADD  = 2'b00,
      OP_MUL  = 2'b01,
      OP_MADD = 2'b10,
      OP_SHLI = 2'b11
   } exu_op_e;

   function automatic logic op_is_mul(input exu_op_e o);
      return (o == OP_MUL) || (o == OP_MADD);
   endfunction
endpackage

// File: rtl/exu_adder.sv
module exu_adder #(
   parameter int DATA_W = 24
) (
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   output logic [DATA_W-1:0] sum
);
   assign sum = x + y;
endmodule

// File: rtl/exu_shl.sv
module exu_shl #(
   parameter int DATA_W  = 24,
   parameter int SHAMT_W = 5,
   parameter bit BARREL  = 1'b1
) (
   input  logic [DATA_W-1:0]  imm,
   input  logic [SHAMT_W-1:0] shamt,
   output logic [DATA_W-1:0]  shifted
);
   generate
      if (BARREL) begin : g_barrel
         always_comb begin
            logic [DATA_W-1:0] v;
            v = imm;
            for (int i = 0; i < SHAMT_W; i++) begin
               if (shamt[i]) begin
                  if ((1 << i) >= DATA_W) v = '0;
                  else                    v = v << (1 << i);
               end
            end
            shifted = v;
         end
      end else begin : g_direct
         logic [31:0] amt_ext;
         assign amt_ext = {{(32-SHAMT_W){1'b0}}, shamt};
         assign shifted = (amt_ext >= 32'(DATA_W)) ? '0 : (imm << shamt);
      end
   endgenerate
endmodule

// File: rtl/exu_mul_pipe.sv
module exu_mul_pipe #(
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic              with_addend,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [DATA_W-1:0] c,
   output logic              busy1,
   output logic              done,
   output logic [DATA_W-1:0] product,
   output logic [DATA_W-1:0] addend
);
   localparam int LO_W = DATA_W / 2;
   localparam int HI_W = DATA_W - LO_W;

   logic [DATA_W-1:0] b_lo_ext, b_hi_ext;
   logic [DATA_W-1:0] pp_lo, pp_hi;
   logic [DATA_W-1:0] s1_lo, s1_hi, s1_c;
   logic              s1_v, s2_v;
   logic [DATA_W-1:0] s2_prod, s2_c;

   assign b_lo_ext = {{(DATA_W-LO_W){1'b0}}, b[LO_W-1:0]};
   assign b_hi_ext = {{(DATA_W-HI_W){1'b0}}, b[DATA_W-1:LO_W]};
   assign pp_lo    = a * b_lo_ext;
   assign pp_hi    = a * b_hi_ext;

   // stage 1: partial products for both halves of b
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v  <= 1'b0;
         s1_lo <= '0;
         s1_hi <= '0;
         s1_c  <= '0;
      end else begin
         s1_v <= launch;
         if (launch) begin
            s1_lo <= pp_lo;
            s1_hi <= pp_hi;
            s1_c  <= with_addend ? c : '0;
         end
      end
   end

   // stage 2: merge partial products
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_v    <= 1'b0;
         s2_prod <= '0;
         s2_c    <= '0;
      end else begin
         s2_v <= s1_v;
         if (s1_v) begin
            s2_prod <= s1_lo + (s1_hi << LO_W);
            s2_c    <= s1_c;
         end
      end
   end

   assign busy1   = s1_v;
   assign done    = s2_v;
   assign product = s2_prod;
   assign addend  = s2_c;
endmodule

// File: rtl/mac_shift_exu.sv
module mac_shift_exu #(
   parameter int DATA_W    = 24,
   parameter int SHAMT_W   = 5,
   parameter bit BARREL_SH = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [1:0]         op,
   input  logic [DATA_W-1:0]  src_a,
   input  logic [DATA_W-1:0]  src_b,
   input  logic [DATA_W-1:0]  src_c,
   input  logic [DATA_W-1:0]  imm,
   input  logic [SHAMT_W-1:0] shamt,
   output logic               res_valid,
   output logic [DATA_W-1:0]  result,
   output logic               stall
);
   import mac_shift_exu_pkg::*;

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("mac_shift_exu: DATA_W must be even and at least 4");
      end
      if (SHAMT_W < 1 || SHAMT_W > 31) begin : g_bad_shamt
         $error("mac_shift_exu: SHAMT_W must be in 1..31");
      end
   endgenerate

   exu_op_e           op_e;
   logic              is_mul, busy1, done, idle, launch;
   logic [DATA_W-1:0] product, addend, add_x, add_y, add_sum, shl_out;

   assign op_e   = exu_op_e'(op);
   assign is_mul = op_is_mul(op_e);
   assign idle   = !busy1 && !done;
   assign launch = in_valid && idle && is_mul;

   exu_mul_pipe #(.DATA_W(DATA_W)) u_mul (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (launch),
      .with_addend (op_e == OP_MADD),
      .a           (src_a),
      .b           (src_b),
      .c           (src_c),
      .busy1       (busy1),
      .done        (done),
      .product     (product),
      .addend      (addend)
   );

   // shared adder: register add, or final product + addend
   assign add_x = done ? product : src_a;
   assign add_y = done ? addend  : src_b;

   exu_adder #(.DATA_W(DATA_W)) u_add (
      .x   (add_x),
      .y   (add_y),
      .sum (add_sum)
   );

   exu_shl #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .BARREL(BARREL_SH)) u_shl (
      .imm     (imm),
      .shamt   (shamt),
      .shifted (shl_out)
   );

   assign result    = (!done && op_e == OP_SHLI) ? shl_out : add_sum;
   assign res_valid = done || (in_valid && idle && !is_mul);
   assign stall     = launch || busy1;
endmodule

// File: rtl/mac_shift_exu_chk.sv
module mac_shift_exu_chk #(
   parameter int DATA_W  = 24,
   parameter int SHAMT_W = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [1:0]         op,
   input logic [DATA_W-1:0]  src_a,
   input logic [DATA_W-1:0]  src_b,
   input logic [DATA_W-1:0]  src_c,
   input logic [DATA_W-1:0]  imm,
   input logic [SHAMT_W-1:0] shamt,
   input logic               res_valid,
   input logic [DATA_W-1:0]  result,
   input logic               stall
);
   logic              pend1, pend2, acc_mul, mul_op;
   logic [DATA_W-1:0] exp1, exp2, exp_now;

   assign mul_op  = (op == 2'b01) || (op == 2'b10);
   assign acc_mul = in_valid && mul_op && !pend1 && !pend2;
   assign exp_now = (op == 2'b10) ? DATA_W'(src_a * src_b + src_c)
                                  : DATA_W'(src_a * src_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend1 <= 1'b0;
         pend2 <= 1'b0;
         exp1  <= '0;
         exp2  <= '0;
      end else begin
         pend1 <= acc_mul;
         pend2 <= pend1;
         if (acc_mul) exp1 <= exp_now;
         exp2 <= exp1;
      end
   end

   // R2, R3: value and latency of multiply-type results
   a_r2_mul_result: assert property (@(posedge clk) disable iff (!rst_n)
      pend2 |-> (res_valid && result == exp2));
   a_r3_madd_latency: assert property (@(posedge clk) disable iff (!rst_n)
      acc_mul |-> ##2 res_valid);
   // R6: stall shape
   a_r6_stall_accept: assert property (@(posedge clk) disable iff (!rst_n)
      acc_mul |-> stall);
   a_r6_stall_second: assert property (@(posedge clk) disable iff (!rst_n)
      acc_mul |=> stall);
   a_r6_stall_drop: assert property (@(posedge clk) disable iff (!rst_n)
      pend2 |-> !stall);
   // R7: nothing extra while in flight
   a_r7_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
      pend1 |-> !res_valid);
   // R1, R4: single-cycle operations
   a_r1_comb_ops: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mul_op && !pend1 && !pend2) |-> (res_valid && !stall));
   // R8: quiet when idle
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !pend1 && !pend2) |-> (!res_valid && !stall));
endmodule

bind mac_shift_exu mac_shift_exu_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op        (op),
   .src_a     (src_a),
   .src_b     (src_b),
   .src_c     (src_c),
   .imm       (imm),
   .shamt     (shamt),
   .res_valid (res_valid),
   .result    (result),
   .stall     (stall)
);

// File: tb/mac_shift_exu_tb.sv
`timescale 1ns/1ps
module mac_shift_exu_tb;
   localparam int DW = 24;
   localparam logic [DW-1:0] MASK = {DW{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    op = 2'b00;
   logic [DW-1:0] src_a = '0, src_b = '0, src_c = '0, imm = '0;
   logic [4:0]    shamt = '0;
   logic          res_valid, stall;
   logic [DW-1:0] result;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mac_shift_exu u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .src_a(src_a), .src_b(src_b), .src_c(src_c), .imm(imm), .shamt(shamt),
      .res_valid(res_valid), .result(result), .stall(stall)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // single-cycle operation; sample after inputs settle, before next edge
   task automatic run_comb(input logic [1:0] o, input logic [DW-1:0] a, input logic [DW-1:0] b,
                           input logic [DW-1:0] im, input logic [4:0] sh,
                           input logic [DW-1:0] exp, input string tag);
      @(negedge clk);
      in_valid = 1'b1; op = o; src_a = a; src_b = b; imm = im; shamt = sh; src_c = 24'h5a5a5a;
      #2;
      chk({tag, " valid"}, 32'(res_valid), 32'd1);
      chk({tag, " stall"}, 32'(stall), 32'd0);
      chk({tag, " value"}, 32'(result), 32'(exp));
   endtask

   // multiply-type: stall shape, ignored inputs, result two cycles on
   task automatic run_mul(input logic [1:0] o, input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic [DW-1:0] c, input string tag);
      logic [2*DW-1:0] full;
      logic [DW-1:0]   exp;
      full = (2*DW)'(a) * (2*DW)'(b) + ((o == 2'b10) ? (2*DW)'(c) : '0);
      exp  = full[DW-1:0] & MASK;
      @(negedge clk);
      in_valid = 1'b1; op = o; src_a = a; src_b = b; src_c = c;
      #2;
      chk({tag, " R6 stall accept"}, 32'(stall), 32'd1);
      chk({tag, " R6 no valid accept"}, 32'(res_valid), 32'd0);
      @(negedge clk);
      op = 2'b00; src_a = 24'h111111; src_b = 24'h222222; src_c = 24'h333333;
      #2;
      chk({tag, " R6 stall second"}, 32'(stall), 32'd1);
      chk({tag, " R7 ignored input"}, 32'(res_valid), 32'd0);
      @(negedge clk);
      op = 2'b11; imm = 24'h000001; shamt = 5'd3;
      #2;
      chk({tag, " R6 stall drop"}, 32'(stall), 32'd0);
      chk({tag, " valid at +2"}, 32'(res_valid), 32'd1);
      chk({tag, " value"}, 32'(result), 32'(exp));
      @(negedge clk);
      in_valid = 1'b0;
      #2;
      chk({tag, " R7 no extra result"}, 32'(res_valid), 32'd0);
      chk({tag, " R7 no extra stall"}, 32'(stall), 32'd0);
   endtask

   task automatic test_reset();
      @(negedge clk);
      chk("R8 reset res_valid", 32'(res_valid), 32'd0);
      chk("R8 reset stall", 32'(stall), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk("R8 idle res_valid", 32'(res_valid), 32'd0);
      chk("R8 idle stall", 32'(stall), 32'd0);
   endtask

   task automatic test_add();
      run_comb(2'b00, 24'h000123, 24'h000456, '0, '0, 24'h000579, "R1 add");
      run_comb(2'b00, 24'hfffff0, 24'h000020, '0, '0, 24'h000010, "R1 add wrap");
   endtask

   task automatic test_shl();
      run_comb(2'b11, '0, '0, 24'h0000ab, 5'd4,  24'h000ab0, "R4 shl 4");
      run_comb(2'b11, '0, '0, 24'h000003, 5'd23, 24'h800000, "R4 shl 23 truncated");
      run_comb(2'b11, '0, '0, 24'h00ffff, 5'd0,  24'h00ffff, "R4 shl 0");
      run_comb(2'b11, '0, '0, 24'hffffff, 5'd24, 24'h000000, "R5 shl 24");
      run_comb(2'b11, '0, '0, 24'h000001, 5'd31, 24'h000000, "R5 shl 31");
   endtask

   task automatic test_mul();
      run_mul(2'b01, 24'h000123, 24'h000045, 24'h777777, "R2 mul small");
      run_mul(2'b01, 24'h123456, 24'h89abcd, '0, "R2 mul wrap");
      run_mul(2'b10, 24'h003000, 24'h400002, 24'h00000f, "R3 madd");
      run_mul(2'b10, 24'hffffff, 24'hffffff, 24'hffffff, "R3 madd wrap");
   endtask

   task automatic test_back_to_back();
      run_comb(2'b00, 24'h000001, 24'h000002, '0, '0, 24'h000003, "R1 back to back a");
      run_comb(2'b11, '0, '0, 24'h000005, 5'd1, 24'h00000a, "R4 back to back b");
      @(negedge clk);
      in_valid = 1'b0;
      #2;
      chk("R8 idle after ops", 32'(res_valid), 32'd0);
   endtask

   initial begin
      test_reset();
      test_add();
      test_shl();
      test_mul();
      test_back_to_back();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule